// File: doc/BRIEF.md
# Ring-Ordered Prefix-Scan Arbiter

This block chooses at most one client out of N per clock cycle and gives the clients turns in a ring. A one-hot marker holds the position of the client served most recently. The next grant goes to the first client that is requesting, searching forward from just past the marker. After index N-1 the search continues at index 0, so the clients behave as a circle. The marker itself is the last position the search reaches.

The search does not ripple from one client to the next. It is a parallel-prefix network with a depth of log2(2N) levels, built from one associative operator. Each position contributes three flags: the marker is present, a request is present, and a request has already been found after the marker. The request vector is scanned twice, end to end, which gives the wrap-around. The two halves of the resulting grant vector are then ORed together.

Requests are sampled on the rising clock edge. The grant for that edge is registered, and the marker moves to the granted client at the same edge. A cycle with no requests leaves the marker where it is.

Top module: `rr_prefix_arbiter`

## Requirements
- R1: While reset is active and in the first cycle after it, `grant_o` is all zeros and `last_served_o` is one-hot at bit N-1, so client 0 has the highest priority first.
- R2: `grant_o` is always either all zeros or has exactly one bit set.
- R3: A bit of `grant_o` is set only if the same bit of `req_i` was set at the clock edge that produced that grant.
- R4: If `req_i` is all zeros at a clock edge, `grant_o` is all zeros after that edge and `last_served_o` does not change.
- R5: If any request is present at an edge, `grant_o` after that edge holds the first requesting index found by stepping upward from (marker index + 1) modulo N.
- R6: The search wraps from index N-1 to index 0. If the only requester is the client at the marker, that client is granted again.
- R7: The grant is registered one cycle after the requests are sampled. At that same edge, `last_served_o` takes the value of the new grant.
- R8: If all N clients request continuously, the grants visit the indices in increasing order, one per cycle, and wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; rising edge samples requests |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | N | Request bit per client, bit i is client i |
| grant_o | output | N | Registered one-hot grant, or zero |
| last_served_o | output | N | One-hot marker of the most recently served client |

## Verification
The bench concentrates on the corners of the ring.

- **Marker at the top index:** a design that fails to wrap either grants nothing or grants a higher index that does not exist.
- **Marker holder is the only requester:** a scan that counts the marker's own slot as the start of the search would starve this client.
- **No requests at all:** a faulty design might clear or move the marker, which shifts every later grant.
- **All clients requesting without pause:** this exposes an off-by-one in the start position, which shows up as repeated or skipped indices.

Beyond these cases, random request patterns are compared against a sequential step-by-step search.

// File: rtl/rr_pkg.sv
package rr_pkg;

    // Scan element: marker seen, request seen, request found after marker
    typedef struct packed {
        logic tok;
        logic req;
        logic hit;
    } scan_t;

    localparam scan_t SCAN_IDENT = '0;

    // Associative combine; lo covers earlier positions than hi
    function automatic scan_t scan_join(scan_t lo, scan_t hi);
        scan_t r;
        r.tok = lo.tok | hi.tok;
        r.req = lo.req | hi.req;
        r.hit = lo.hit | hi.hit | (lo.tok & hi.req);
        return r;
    endfunction

endpackage

// File: rtl/rr_prefix_scan.sv
module rr_prefix_scan
    import rr_pkg::*;
#(
    parameter int W = 16
) (
    input  scan_t [W-1:0] leaf_i,
    output scan_t [W-1:0] excl_o
);
    localparam int LEVELS = (W > 1) ? $clog2(W) : 1;

    scan_t [W-1:0] stage [LEVELS+1];

    assign stage[0] = leaf_i;

    // Kogge-Stone network: level l joins each position with the one 2^l below
    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        localparam int DIST = 1 << l;
        for (genvar i = 0; i < W; i++) begin : g_pos
            if (i >= DIST) begin : g_join
                assign stage[l+1][i] = scan_join(stage[l][i-DIST], stage[l][i]);
            end else begin : g_pass
                assign stage[l+1][i] = stage[l][i];
            end
        end
    end

    // Exclusive prefix: position i sees only positions strictly below it
    assign excl_o[0] = SCAN_IDENT;
    for (genvar i = 1; i < W; i++) begin : g_excl
        assign excl_o[i] = stage[LEVELS][i-1];
    end

endmodule

// File: rtl/rr_grant_fold.sv
module rr_grant_fold
    import rr_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] last_i,
    output logic [N-1:0] grant_o
);
    localparam int M = 2 * N;

    scan_t [M-1:0] leaf_w;
    scan_t [M-1:0] excl_w;
    logic  [M-1:0] raw_w;

    // Requests appear twice; the marker only in the first copy
    for (genvar i = 0; i < M; i++) begin : g_leaf
        if (i < N) begin : g_lo
            assign leaf_w[i] = '{tok: last_i[i], req: req_i[i], hit: 1'b0};
        end else begin : g_hi
            assign leaf_w[i] = '{tok: 1'b0, req: req_i[i-N], hit: 1'b0};
        end
    end

    rr_prefix_scan #(.W(M)) scan_i (
        .leaf_i (leaf_w),
        .excl_o (excl_w)
    );

    for (genvar i = 0; i < M; i++) begin : g_raw
        assign raw_w[i] = leaf_w[i].req & excl_w[i].tok & ~excl_w[i].hit;
    end

    // Fold the doubled vector back onto the ring
    assign grant_o = raw_w[N-1:0] | raw_w[M-1:N];

endmodule

// File: rtl/rr_prefix_arbiter.sv
module rr_prefix_arbiter #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic [N-1:0] last_served_o
);
    typedef struct packed {
        logic [N-1:0] grant;
        logic [N-1:0] last;
    } arb_state_t;

    localparam logic [N-1:0] LAST_RST = {1'b1, {(N-1){1'b0}}};
    localparam arb_state_t   STATE_RST = '{grant: '0, last: LAST_RST};

    arb_state_t   state_d, state_q;
    logic [N-1:0] pick_w;

    rr_grant_fold #(.N(N)) fold_i (
        .req_i   (req_i),
        .last_i  (state_q.last),
        .grant_o (pick_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.grant = pick_w;
        if (|pick_w) begin
            state_d.last = pick_w;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= STATE_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign grant_o       = state_q.grant;
    assign last_served_o = state_q.last;

    // R2
    grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant_o));

    // R3
    grant_requested_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i != '0) |=> ((grant_o & ~$past(req_i)) == '0));

    // R4
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i == '0) |=> (grant_o == '0 && $stable(last_served_o)));

    // R5
    busy_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i != '0) |=> (grant_o != '0));

    // R1
    marker_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot(last_served_o));

endmodule

// File: tb/rr_prefix_arbiter_tb.sv
module rr_prefix_arbiter_tb_top;
    localparam int N = 8;
    localparam int WATCHDOG_CYCLES = 20000;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic [N-1:0] req_i = '0;
    logic [N-1:0] grant_o;
    logic [N-1:0] last_served_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    int exp_last = N - 1;

    logic [N-1:0] q_grant[$];
    logic [N-1:0] q_last[$];
    string        q_tag[$];

    always #5 clk_i = ~clk_i;

    rr_prefix_arbiter #(.N(N)) dut_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .req_i         (req_i),
        .grant_o       (grant_o),
        .last_served_o (last_served_o)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Sequential reference: step upward from marker+1, wrapping
    function automatic int ref_pick(input logic [N-1:0] r, input int last);
        for (int k = 1; k <= N; k++) begin
            int idx = (last + k) % N;
            if (r[idx]) return idx;
        end
        return -1;
    endfunction

    task automatic drive(input logic [N-1:0] r, input string tag);
        int w;
        logic [N-1:0] g;
        @(negedge clk_i);
        req_i = r;
        w = ref_pick(r, exp_last);
        g = '0;
        if (w >= 0) begin
            g[w] = 1'b1;
            exp_last = w;
        end
        q_grant.push_back(g);
        q_last.push_back(N'(1) << exp_last);
        q_tag.push_back(tag);
    endtask

    // Monitor: samples after each rising edge has settled
    initial begin
        forever begin
            @(posedge clk_i);
            #2;
            if (q_grant.size() > 0) begin
                logic [N-1:0] eg, el;
                string t;
                eg = q_grant.pop_front();
                el = q_last.pop_front();
                t  = q_tag.pop_front();
                check(grant_o == eg, {t, " R7 grant"}, grant_o, eg);
                check(last_served_o == el, {t, " R7 marker"}, last_served_o, el);
                check($countones(grant_o) <= 1, "R2 onehot", grant_o, eg);
                check((grant_o & ~req_i) == '0, "R3 granted client requested", grant_o, req_i);
            end
        end
    end

    initial begin
        #(WATCHDOG_CYCLES * 10);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] r;
        repeat (3) @(posedge clk_i);
        #2;
        check(grant_o == '0, "R1 reset grant", grant_o, '0);
        check(last_served_o == (N'(1) << (N-1)), "R1 reset marker",
              last_served_o, N'(1) << (N-1));
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(posedge clk_i);
        #2;
        check(last_served_o == (N'(1) << (N-1)), "R1 marker after reset",
              last_served_o, N'(1) << (N-1));

        // R6: wrap from the top index to index 0
        drive(8'b0010_0001, "R6 wrap");
        // R5: marker at 0, next requester above it
        drive(8'b0100_0001, "R5 forward");
        // R6: only the marker holder requests
        drive(8'b0100_0000, "R6 self");
        // R4: idle cycles keep the marker
        drive('0, "R4 idle");
        drive('0, "R4 idle");
        drive(8'b0000_0010, "R4 after idle");
        // R8: all requesting, rotation over more than one lap
        for (int k = 0; k < N + 3; k++) drive('1, "R8 rotate");
        // R5: random patterns, some sparse
        for (int k = 0; k < 400; k++) begin
            r = N'($urandom);
            if (k % 3 == 0) r = r & N'($urandom);
            drive(r, "R5 random");
        end
        drive('0, "R4 idle end");
        repeat (3) @(posedge clk_i);
        #3;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule